// File: doc/BRIEF.md
# Comparator-Driven Tracking ADC Controller

This block is the digital half of a tracking analog-to-digital converter. An external analog comparator reports whether the input voltage lies above the voltage produced by a high-resolution DAC. On each update strobe, the block reads that comparator bit and nudges a 16-bit DAC code toward the input. The step is a small fixed amount, a fraction of one 8-bit LSB. The code is kept within a floor of zero and a ceiling of 0xFF00, and it is driven straight to the DAC. There is no calibration phase. The loop simply runs for as long as strobes arrive.

The upper byte of the code is the conversion result. Because each step is smaller than one LSB of that byte, the low bits dither around the input while the byte holds steady. The byte changes only when the input actually crosses a threshold. A registered copy of the byte is provided together with a valid flag and a one-cycle change pulse.

Two guards against running below zero are offered. The clamp variant computes a signed difference and saturates at zero. The skip variant simply leaves the code alone when it is already zero and a decrease is requested.

Top module: `trk_adc_core`

## Requirements
- R1: While `rst` is high at a clock edge, `dac_code` becomes 0x0000, `result` 0x00, and `result_vld` and `result_chg` 0.
- R2: At an edge where `update_en` is 1 and the synchronized comparator is 1, `dac_code` grows by `STEP` (default 0x0055) when the sum stays at or below `CEIL`.
- R3: At an edge where `update_en` is 1 and the synchronized comparator is 0, `dac_code` shrinks by `STEP` when the code is at least `STEP`.
- R4: An increase that would pass `CEIL` (default 0xFF00) yields exactly `CEIL`. The code never wraps, and this holds for any legal step, including 0x0033.
- R5: In the clamp variant (`GUARD` = `GUARD_CLAMP`), a decrease from a code below `STEP` yields exactly 0x0000.
- R6: In the skip variant (`GUARD` = `GUARD_SKIP`), a decrease requested at code 0x0000 leaves the code at 0x0000. This variant requires `CEIL` to be a multiple of `STEP`.
- R7: When `update_en` is 0, `dac_code` and `result` keep their values whatever `cmp_async` does.
- R8: `result` equals bits [15:8] of `dac_code` after every update, and it is updated at the same edge as the code.
- R9: `result_vld` stays 0 from reset until the first update, and then stays 1 until the next reset.
- R10: `result_chg` is 1 for exactly the one cycle after an update that changed `result`, and 0 otherwise.
- R11: `cmp_async` passes through a two-flop synchronizer. A change in it is first used by a strobe sampled at the third rising edge after the change; strobes sampled at the first and second edges still use the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_async | input | 1 | Asynchronous comparator bit; 1 means the input is above the DAC output |
| update_en | input | 1 | One-cycle strobe that triggers one tracking step |
| dac_code | output | 16 | Tracking level driven to the DAC |
| result | output | 8 | Registered conversion result, the top byte of the level |
| result_vld | output | 1 | High once the first update after reset has occurred |
| result_chg | output | 1 | One-cycle pulse when `result` took a new value |

## Verification
`dac_code`, `result`, `result_vld` and `result_chg` all change at the rising edge that samples `update_en` high, so the bench raises the strobe at a falling edge and reads every output at the following falling edge, one cycle later. A comparator change needs two further edges before it reaches the stepping logic. For that reason, the table-driven part holds `cmp_async` steady for three cycles before any strobe. The synchronizer test then deliberately places strobes at the first, second and third edges after a change, expecting down, down and then up.

// File: rtl/trk_adc_pkg.sv
package trk_adc_pkg;

   // Selects how a decrease near zero is handled.
   typedef enum logic {
      GUARD_CLAMP = 1'b0,  // signed difference, saturate at zero
      GUARD_SKIP  = 1'b1   // hold the level when it is already zero
   } trk_guard_e;

endpackage

// File: rtl/trk_adc_sync.sv
module trk_adc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic d_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("trk_adc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= 1'b0;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/trk_adc_step.sv
module trk_adc_step
   import trk_adc_pkg::*;
#(
   parameter int              LEVEL_W = 16,
   parameter logic [LEVEL_W-1:0] STEP = 16'h0055,
   parameter logic [LEVEL_W-1:0] CEIL = 16'hFF00,
   parameter trk_guard_e      GUARD   = GUARD_CLAMP
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               upd,
   input  logic               go_up,
   output logic [LEVEL_W-1:0] lvl_nxt,
   output logic [LEVEL_W-1:0] lvl_q
);

   // Highest level from which a full step up still fits under the ceiling.
   localparam logic [LEVEL_W-1:0] UP_LIM = CEIL - STEP;

   logic [LEVEL_W-1:0] up_val;
   logic [LEVEL_W-1:0] dn_val;

   // Saturating increase: compare before adding, so the sum never wraps.
   always_comb begin
      if (lvl_q >= UP_LIM) up_val = CEIL;
      else                 up_val = lvl_q + STEP;
   end

   generate
      if (GUARD == GUARD_CLAMP) begin : g_clamp
         logic [LEVEL_W:0] diff;
         always_comb begin
            diff = {1'b0, lvl_q} - {1'b0, STEP};
            if (diff[LEVEL_W]) dn_val = '0;
            else               dn_val = diff[LEVEL_W-1:0];
         end
      end else begin : g_skip
         // Level is always a multiple of STEP here, so only zero needs care.
         always_comb begin
            if (lvl_q == '0) dn_val = lvl_q;
            else             dn_val = lvl_q - STEP;
         end
      end
   endgenerate

   always_comb begin
      if (!upd)       lvl_nxt = lvl_q;
      else if (go_up) lvl_nxt = up_val;
      else            lvl_nxt = dn_val;
   end

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl_nxt;
   end

endmodule

// File: rtl/trk_adc_result.sv
module trk_adc_result #(
   parameter int LEVEL_W = 16,
   parameter int RES_W   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               upd,
   input  logic [LEVEL_W-1:0] lvl_nxt,
   output logic [RES_W-1:0]   res_q,
   output logic               vld_q,
   output logic               chg_q
);

   localparam int LO = LEVEL_W - RES_W;

   logic [RES_W-1:0] top_byte;
   assign top_byte = lvl_nxt[LEVEL_W-1:LO];

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         vld_q <= 1'b0;
         chg_q <= 1'b0;
      end else if (upd) begin
         vld_q <= 1'b1;
         chg_q <= (top_byte != res_q);
         if (top_byte != res_q) res_q <= top_byte;
      end else begin
         chg_q <= 1'b0;
      end
   end

endmodule

// File: rtl/trk_adc_core.sv
module trk_adc_core
   import trk_adc_pkg::*;
#(
   parameter int                 LEVEL_W     = 16,
   parameter int                 RES_W       = 8,
   parameter logic [LEVEL_W-1:0] STEP        = 16'h0055,
   parameter logic [LEVEL_W-1:0] CEIL        = 16'hFF00,
   parameter trk_guard_e         GUARD       = GUARD_CLAMP,
   parameter int                 SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmp_async,
   input  logic               update_en,
   output logic [LEVEL_W-1:0] dac_code,
   output logic [RES_W-1:0]   result,
   output logic               result_vld,
   output logic               result_chg
);

   generate
      if (RES_W > LEVEL_W || RES_W < 1) begin : g_bad_res
         $error("trk_adc_core: RES_W must be in 1..LEVEL_W");
      end
      if (STEP == '0) begin : g_bad_step
         $error("trk_adc_core: STEP must be nonzero");
      end
      if (STEP > CEIL) begin : g_bad_ceil
         $error("trk_adc_core: STEP must not exceed CEIL");
      end
      if (GUARD == GUARD_SKIP && (CEIL % STEP) != 0) begin : g_bad_skip
         $error("trk_adc_core: skip guard needs CEIL to be a multiple of STEP");
      end
   endgenerate

   logic                cmp_s;
   logic [LEVEL_W-1:0]  lvl_nxt;

   trk_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (cmp_async),
      .d_sync  (cmp_s)
   );

   trk_adc_step #(
      .LEVEL_W (LEVEL_W),
      .STEP    (STEP),
      .CEIL    (CEIL),
      .GUARD   (GUARD)
   ) u_step (
      .clk     (clk),
      .rst     (rst),
      .upd     (update_en),
      .go_up   (cmp_s),
      .lvl_nxt (lvl_nxt),
      .lvl_q   (dac_code)
   );

   trk_adc_result #(
      .LEVEL_W (LEVEL_W),
      .RES_W   (RES_W)
   ) u_res (
      .clk     (clk),
      .rst     (rst),
      .upd     (update_en),
      .lvl_nxt (lvl_nxt),
      .res_q   (result),
      .vld_q   (result_vld),
      .chg_q   (result_chg)
   );

endmodule

// File: rtl/trk_adc_core_chk.sv
module trk_adc_core_chk #(
   parameter int                 LEVEL_W = 16,
   parameter int                 RES_W   = 8,
   parameter logic [LEVEL_W-1:0] STEP    = 16'h0055,
   parameter logic [LEVEL_W-1:0] CEIL    = 16'hFF00
) (
   input logic               clk,
   input logic               rst,
   input logic               update_en,
   input logic               cmp_s,
   input logic [LEVEL_W-1:0] dac_code,
   input logic [RES_W-1:0]   result,
   input logic               result_vld,
   input logic               result_chg
);

   localparam logic [LEVEL_W-1:0] UP_LIM = CEIL - STEP;

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (dac_code == '0 && result == '0 && !result_vld && !result_chg));

   p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
      (update_en && cmp_s && dac_code <= UP_LIM) |=>
         dac_code == LEVEL_W'($past(dac_code) + STEP));

   p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
      (update_en && !cmp_s && dac_code >= STEP) |=>
         dac_code == LEVEL_W'($past(dac_code) - STEP));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
      dac_code <= CEIL);

   p_floor_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (update_en && !cmp_s && dac_code == '0) |=> dac_code == '0);

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !update_en |=> ($stable(dac_code) && $stable(result)));

   p_byte_r8: assert property (@(posedge clk) disable iff (rst)
      result_vld |-> result == dac_code[LEVEL_W-1:LEVEL_W-RES_W]);

   p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      result_vld |=> result_vld);

   p_chg_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      result_chg |=> !result_chg || $past(update_en));

endmodule

bind trk_adc_core trk_adc_core_chk #(
   .LEVEL_W (LEVEL_W),
   .RES_W   (RES_W),
   .STEP    (STEP),
   .CEIL    (CEIL)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .update_en  (update_en),
   .cmp_s      (cmp_s),
   .dac_code   (dac_code),
   .result     (result),
   .result_vld (result_vld),
   .result_chg (result_chg)
);

// File: tb/trk_adc_core_bench.sv
module trk_adc_core_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmp_async = 1'b0;
   logic        update_en = 1'b0;

   logic [15:0] code_a, code_b;
   logic [7:0]  res_a, res_b;
   logic        vld_a, vld_b, chg_a, chg_b;

   int checks = 0;
   int errors = 0;

   // Bench models of the two levels.
   logic [15:0] m_a, m_b;

   localparam logic [15:0] STEP_A = 16'h0055;
   localparam logic [15:0] STEP_B = 16'h0033;
   localparam logic [15:0] CEIL   = 16'hFF00;

   always #10 clk = ~clk;

   trk_adc_core u_trk_adc_core (
      .clk(clk), .rst(rst), .cmp_async(cmp_async), .update_en(update_en),
      .dac_code(code_a), .result(res_a), .result_vld(vld_a), .result_chg(chg_a)
   );

   trk_adc_core #(
      .STEP(STEP_B), .GUARD(trk_adc_pkg::GUARD_SKIP)
   ) u_trk_adc_core_skip (
      .clk(clk), .rst(rst), .cmp_async(cmp_async), .update_en(update_en),
      .dac_code(code_b), .result(res_b), .result_vld(vld_b), .result_chg(chg_b)
   );

   // Stimulus table: {comparator bit, number of strobes}.
   localparam int NVEC = 8;
   localparam logic [11:0] VEC [NVEC] = '{
      {1'b1, 11'd10},   // R2 climb from zero
      {1'b0, 11'd3},    // R3 descend
      {1'b1, 11'd1},
      {1'b0, 11'd1},
      {1'b1, 11'd1300}, // R4 run into the ceiling
      {1'b0, 11'd7},
      {1'b1, 11'd20},   // R4 ceiling again
      {1'b0, 11'd1400}  // R5/R6 run into the floor
   };

   function automatic logic [15:0] mdl(input logic [15:0] l, input logic up,
                                       input logic [15:0] st);
      if (up) begin
         if (32'(l) + 32'(st) > 32'(CEIL)) return CEIL;
         return l + st;
      end
      if (l < st) return 16'h0000;
      return l - st;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      check({req, " code_a"}, 32'(code_a), 32'(m_a));
      check({req, " code_b"}, 32'(code_b), 32'(m_b));
      check("R8 res_a", 32'(res_a), 32'(m_a[15:8]));
      check("R8 res_b", 32'(res_b), 32'(m_b[15:8]));
   endtask

   // One strobe with the comparator already settled to 'up'.
   task automatic strobe(input logic up, input string req);
      logic [15:0] oa, ob;
      oa = m_a; ob = m_b;
      @(negedge clk) update_en = 1'b1;
      @(negedge clk) update_en = 1'b0;
      m_a = mdl(m_a, up, STEP_A);
      m_b = mdl(m_b, up, STEP_B);
      if (code_a !== m_a || code_b !== m_b) check_state(req);
      else checks++;
      if (chg_a !== (m_a[15:8] != oa[15:8]) || chg_b !== (m_b[15:8] != ob[15:8])) begin
         checks++; errors++;
         $display("FAIL R10 chg_a=%b chg_b=%b expected %b %b", chg_a, chg_b,
                  m_a[15:8] != oa[15:8], m_b[15:8] != ob[15:8]);
      end else checks++;
      @(negedge clk);
      check("R10 chg_a low after pulse", 32'(chg_a), 32'd0);
   endtask

   task automatic set_cmp(input logic v);
      @(negedge clk) cmp_async = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      m_a = '0; m_b = '0;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_a = '0; m_b = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 code", 32'(code_a), 32'd0);
      check("R1 result", 32'(res_a), 32'd0);
      check("R1 vld", 32'(vld_a), 32'd0);
      check("R1 chg", 32'(chg_a), 32'd0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 vld low before first update", 32'(vld_a), 32'd0);

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         set_cmp(VEC[v][11]);
         for (int k = 0; k < int'(VEC[v][10:0]); k++) strobe(VEC[v][11], "R2/R3/R4");
         check_state("R4/R5/R6 table end");
         check("R9 vld high", 32'(vld_a & vld_b), 32'd1);
      end
      check("R4 ceiling reached then floor", 32'(code_a), 32'd0);

      // R4 exact ceiling with both step sizes
      set_cmp(1'b1);
      for (int k = 0; k < 1300; k++) strobe(1'b1, "R4 climb");
      check("R4 exact ceil step 0x55", 32'(code_a), 32'hFF00);
      check("R4 exact ceil step 0x33", 32'(code_b), 32'hFF00);

      // R5 clamp from below STEP: reach 0x0033 on A is impossible with 0x55
      // steps, so reset and craft 0x0055 -> down -> 0 -> down -> 0.
      do_reset();
      set_cmp(1'b1);
      strobe(1'b1, "R2 single");
      check("R2 code 0x0055", 32'(code_a), 32'h0055);
      set_cmp(1'b0);
      strobe(1'b0, "R3 single");
      strobe(1'b0, "R5 floor clamp");
      check("R5 code stays zero", 32'(code_a), 32'd0);
      check("R6 skip stays zero", 32'(code_b), 32'd0);

      // R7 no strobe: comparator toggles, outputs hold
      set_cmp(1'b1);
      for (int k = 0; k < 8; k++) strobe(1'b1, "R7 setup");
      for (int k = 0; k < 10; k++) @(negedge clk) cmp_async = ~cmp_async;
      repeat (4) @(negedge clk);
      check_state("R7 hold without strobe");

      // R11 synchronizer latency: cmp 0 settled, then flip with strobes
      set_cmp(1'b0);
      @(negedge clk) begin cmp_async = 1'b1; update_en = 1'b1; end
      @(negedge clk);
      @(negedge clk);
      @(negedge clk) update_en = 1'b0;
      m_a = mdl(mdl(mdl(m_a, 1'b0, STEP_A), 1'b0, STEP_A), 1'b1, STEP_A);
      m_b = mdl(mdl(mdl(m_b, 1'b0, STEP_B), 1'b0, STEP_B), 1'b1, STEP_B);
      check_state("R11 down down up");

      // R1 reset mid-run
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      check("R1 mid reset code", 32'(code_a), 32'd0);
      check("R1 mid reset vld", 32'(vld_a), 32'd0);
      rst = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule